// File: doc/BRIEF.md
# Storage Channel Mode and Command Registers

This block is the write-side register front end of one channel in a multi-channel storage controller. It watches a shared write bus. It accepts only the accesses that fall in its own channel window, which repeats every 16 KiB. It turns byte, halfword and word writes into byte-lane updates of the channel's configuration. That configuration holds the 64-bit base address of the command packet, a power-of-two packet spacing and four 16-bit FIFO thresholds.

The block also holds the channel's operating mode. After reset the channel is in register mode. Software fills in the packet base and then writes the run command word to the command register. The channel then enters packet mode and emits a one-cycle start pulse, with the packet base on a parallel output. The packet engine outside this block raises a done strobe when it finishes, and the channel returns to register mode. Software can also force register mode at any time.

Control writes to the two control bytes produce single-cycle pulses for error clear, link reset and channel reset. A run command that arrives while a packet is still active is discarded and recorded in a sticky busy-error flag.

Top module: `chan_ctrl_regs`

## Requirements
- R1: After reset the channel is in register mode, with packet base 0, spacing 6, thresholds 32, 32, 10 and 8, busy error 0 and every pulse output low.
- R2: Only writes whose address bits [15:14] equal CHAN_ID (default 1) have any effect. Reads with other upper bits return 0.
- R3: wr_size_i encodes 0 as byte, 1 as halfword and 2 as word. Data sits on the byte lanes chosen by address bits [1:0]. A halfword at an odd address, a word at an address that is not a multiple of 4, and a read at an address that is not a multiple of 4 are all ignored or return 0.
- R4: The packet base reads and writes as a low word at offset 0x710 and a high word at offset 0x714. Byte and halfword writes update only their own lanes. pkt_base_o always shows the full 64-bit value.
- R5: The spacing exponent is an 8-bit value at offset 0x718, bits [7:0]. The thresholds are 16-bit values in bits [15:0] at offsets 0x800, 0x804, 0x808 and 0x80C. Their upper read bits are 0.
- R6: A word write of 0x00000107 to offset 0xA00 while in register mode raises pkt_start_o for exactly the next cycle and clears reg_mode_o in that same cycle.
- R7: Any other value, or any byte or halfword write, at offset 0xA00 has no effect.
- R8: A run command that arrives in packet mode produces no start pulse. It sets the busy-error flag, which reads at offset 0x900 bit 7 and stays set until it is cleared.
- R9: The channel returns to register mode in the cycle after pkt_done_i while in packet mode, or after a write of byte 0x900 with bit 1 set. Offset 0x900 bit 1 reads the current mode.
- R10: A write of byte 0x900 with bit 2 set pulses err_clr_o for one cycle and clears the busy error.
- R11: In the byte at 0x901, bit 1 pulses phy_rst_o and bit 4 pulses chan_rst_o, each for one cycle. Both bits read back as 0. A channel reset also forces register mode and clears the busy error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 16 | Write byte address, channel select in the top bits |
| wr_size_i | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| wr_data_i | input | 32 | Write data, lane-aligned to the address |
| rd_addr_i | input | 16 | Read byte address, word aligned |
| rd_data_o | output | 32 | Combinational read data |
| pkt_done_i | input | 1 | Packet completion strobe from the packet engine |
| reg_mode_o | output | 1 | 1 in register mode, 0 in packet mode |
| busy_err_o | output | 1 | Sticky flag for a run command received in packet mode |
| pkt_start_o | output | 1 | One-cycle packet start pulse |
| pkt_base_o | output | 64 | Packet base address |
| spacing_o | output | 8 | Packet spacing exponent |
| thr_o | output | 64 | Four thresholds, host-up in bits [15:0] |
| err_clr_o | output | 1 | Error clear pulse |
| phy_rst_o | output | 1 | Link reset pulse |
| chan_rst_o | output | 1 | Channel logic reset pulse |

## Verification
The assertions assume that pkt_done_i arrives only as a single-cycle strobe and that wr_size_i never carries code 3. The bench drives pkt_done_i only after a run has been accepted, holds it for one clock, and uses only the three defined size codes. The bench issues every write as a single-cycle strobe driven at the falling edge, with read addresses held on word boundaries. The misaligned cases are the one place where the alignment rule is broken, and they are broken on purpose.

// File: rtl/chan_regs_pkg.sv
package chan_regs_pkg;
  localparam int WIN_LOG2 = 14;
  localparam int WORD_W   = WIN_LOG2 - 2;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2} wr_size_e;

  localparam logic [WORD_W-1:0] W_BASE_LO = 12'h1C4;
  localparam logic [WORD_W-1:0] W_BASE_HI = 12'h1C5;
  localparam logic [WORD_W-1:0] W_SPACING = 12'h1C6;
  localparam logic [WORD_W-1:0] W_THR0    = 12'h200;
  localparam logic [WORD_W-1:0] W_CTRL    = 12'h240;
  localparam logic [WORD_W-1:0] W_CMD     = 12'h280;

  localparam logic [31:0] RUN_CMD = 32'h0000_0107;

  typedef struct packed {
    logic              hit;
    logic [WORD_W-1:0] word;
    logic [3:0]        be;
    logic [31:0]       data;
  } wr_req_t;

  function automatic logic [31:0] merge32(logic [31:0] old, logic [31:0] d, logic [3:0] be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*b +: 8] = be[b] ? d[8*b +: 8] : old[8*b +: 8];
    return r;
  endfunction

  function automatic logic [15:0] merge16(logic [15:0] old, logic [15:0] d, logic [1:0] be);
    logic [15:0] r;
    for (int b = 0; b < 2; b++) r[8*b +: 8] = be[b] ? d[8*b +: 8] : old[8*b +: 8];
    return r;
  endfunction
endpackage

// File: rtl/chan_addr_dec.sv
module chan_addr_dec
  import chan_regs_pkg::*;
#(
  parameter int N_CHAN  = 4,
  parameter int CHAN_ID = 1,
  localparam int SEL_W  = (N_CHAN > 1) ? $clog2(N_CHAN) : 1,
  localparam int ADDR_W = SEL_W + WIN_LOG2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [1:0]        wr_size_i,
  input  logic [31:0]       wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output wr_req_t           req_o,
  output logic              rd_hit_o,
  output logic [WORD_W-1:0] rd_word_o
);
  localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(CHAN_ID);

  logic       wr_in_win;
  logic [3:0] be;

  assign wr_in_win = (wr_addr_i[ADDR_W-1:WIN_LOG2] == MY_SEL);

  always_comb begin
    be = 4'b0000;
    case (wr_size_e'(wr_size_i))
      SZ_BYTE: be = 4'b0001 << wr_addr_i[1:0];
      SZ_HALF: be = wr_addr_i[0] ? 4'b0000 : (4'b0011 << wr_addr_i[1:0]);
      SZ_WORD: be = (wr_addr_i[1:0] != 2'b00) ? 4'b0000 : 4'b1111;
      default: be = 4'b0000;
    endcase
  end

  assign req_o.hit  = wr_en_i && wr_in_win && (be != 4'b0000);
  assign req_o.word = wr_addr_i[WIN_LOG2-1:2];
  assign req_o.be   = be;
  assign req_o.data = wr_data_i;

  assign rd_hit_o  = (rd_addr_i[ADDR_W-1:WIN_LOG2] == MY_SEL) && (rd_addr_i[1:0] == 2'b00);
  assign rd_word_o = rd_addr_i[WIN_LOG2-1:2];

  // R3
  be_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o.hit |-> ($countones(req_o.be) == 1 || req_o.be == 4'b0011 ||
                   req_o.be == 4'b1100 || req_o.be == 4'b1111));
endmodule

// File: rtl/chan_cfg_regs.sv
module chan_cfg_regs
  import chan_regs_pkg::*;
#(
  parameter int N_THR = 4,
  parameter int THR_W = 16,
  parameter logic [N_THR*THR_W-1:0] THR_RST = {16'd8, 16'd10, 16'd32, 16'd32},
  parameter logic [7:0] SPACING_RST = 8'd6
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  wr_req_t                req_i,
  input  logic [WORD_W-1:0]      rd_word_i,
  output logic [31:0]            rd_data_o,
  output logic [63:0]            base_o,
  output logic [7:0]             spacing_o,
  output logic [N_THR*THR_W-1:0] thr_o
);
  logic [63:0] base_q;
  logic [7:0]  spacing_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q    <= '0;
      spacing_q <= SPACING_RST;
    end else if (req_i.hit) begin
      if (req_i.word == W_BASE_LO) base_q[31:0]  <= merge32(base_q[31:0], req_i.data, req_i.be);
      if (req_i.word == W_BASE_HI) base_q[63:32] <= merge32(base_q[63:32], req_i.data, req_i.be);
      if (req_i.word == W_SPACING && req_i.be[0]) spacing_q <= req_i.data[7:0];
    end
  end

  for (genvar i = 0; i < N_THR; i++) begin : g_thr
    localparam logic [WORD_W-1:0] MY_WORD = W_THR0 + WORD_W'(i);
    logic [THR_W-1:0] thr_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) thr_q <= THR_RST[i*THR_W +: THR_W];
      else if (req_i.hit && req_i.word == MY_WORD)
        thr_q <= THR_W'(merge16(16'(thr_q), req_i.data[15:0], req_i.be[1:0]));
    end
    assign thr_o[i*THR_W +: THR_W] = thr_q;
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_word_i == W_BASE_LO) rd_data_o = base_q[31:0];
    if (rd_word_i == W_BASE_HI) rd_data_o = base_q[63:32];
    if (rd_word_i == W_SPACING) rd_data_o = {24'b0, spacing_q};
    for (int i = 0; i < N_THR; i++)
      if (rd_word_i == W_THR0 + WORD_W'(i)) rd_data_o = 32'(thr_o[i*THR_W +: THR_W]);
  end

  assign base_o    = base_q;
  assign spacing_o = spacing_q;

  // R4
  base_lo_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i.hit && req_i.word == W_BASE_LO) |=> $stable(base_q[31:0]));
  // R4
  base_hi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i.hit && req_i.word == W_BASE_HI) |=> $stable(base_q[63:32]));
  // R5
  spacing_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i.hit && req_i.word == W_SPACING) |=> $stable(spacing_q));
endmodule

// File: rtl/chan_mode_ctl.sv
module chan_mode_ctl
  import chan_regs_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  wr_req_t     req_i,
  input  logic        pkt_done_i,
  output logic        reg_mode_o,
  output logic        busy_err_o,
  output logic        pkt_start_o,
  output logic        err_clr_o,
  output logic        phy_rst_o,
  output logic        chan_rst_o,
  output logic [31:0] ctrl_rd_o
);
  logic ctrl_wr, run_cmd, set_reg, clr_err, phy_req, chan_req, done_eff;
  logic reg_mode_q, busy_q, start_q, clr_q, phy_q, chan_q;

  assign ctrl_wr  = req_i.hit && (req_i.word == W_CTRL);
  assign run_cmd  = req_i.hit && (req_i.word == W_CMD) && (req_i.be == 4'hF) && (req_i.data == RUN_CMD);
  assign set_reg  = ctrl_wr && req_i.be[0] && req_i.data[1];
  assign clr_err  = ctrl_wr && req_i.be[0] && req_i.data[2];
  assign phy_req  = ctrl_wr && req_i.be[1] && req_i.data[9];
  assign chan_req = ctrl_wr && req_i.be[1] && req_i.data[12];
  assign done_eff = pkt_done_i && !reg_mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_mode_q <= 1'b1;
      busy_q     <= 1'b0;
      start_q    <= 1'b0;
      clr_q      <= 1'b0;
      phy_q      <= 1'b0;
      chan_q     <= 1'b0;
    end else begin
      if (chan_req || set_reg || done_eff) reg_mode_q <= 1'b1;
      else if (run_cmd && reg_mode_q)      reg_mode_q <= 1'b0;
      if (chan_req || clr_err)             busy_q <= 1'b0;
      else if (run_cmd && !reg_mode_q)     busy_q <= 1'b1;
      start_q <= run_cmd && reg_mode_q;
      clr_q   <= clr_err;
      phy_q   <= phy_req;
      chan_q  <= chan_req;
    end
  end

  assign reg_mode_o  = reg_mode_q;
  assign busy_err_o  = busy_q;
  assign pkt_start_o = start_q;
  assign err_clr_o   = clr_q;
  assign phy_rst_o   = phy_q;
  assign chan_rst_o  = chan_q;
  assign ctrl_rd_o   = {24'b0, busy_q, 5'b0, reg_mode_q, 1'b0};

  // R6
  start_from_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_start_o |-> ($past(reg_mode_q) && !reg_mode_q));
  // R8
  busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> (!$past(reg_mode_q) && !pkt_start_o));
  // R9
  done_return_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_done_i |=> reg_mode_q);
  // R10
  clr_effect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_clr_o |-> !busy_q);
  // R11
  chan_rst_effect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_rst_o |-> (reg_mode_q && !busy_q));
endmodule

// File: rtl/chan_ctrl_regs.sv
module chan_ctrl_regs
  import chan_regs_pkg::*;
#(
  parameter int N_CHAN  = 4,
  parameter int CHAN_ID = 1,
  parameter int N_THR   = 4,
  parameter int THR_W   = 16,
  localparam int SEL_W  = (N_CHAN > 1) ? $clog2(N_CHAN) : 1,
  localparam int ADDR_W = SEL_W + WIN_LOG2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [ADDR_W-1:0]      wr_addr_i,
  input  logic [1:0]             wr_size_i,
  input  logic [31:0]            wr_data_i,
  input  logic [ADDR_W-1:0]      rd_addr_i,
  output logic [31:0]            rd_data_o,
  input  logic                   pkt_done_i,
  output logic                   reg_mode_o,
  output logic                   busy_err_o,
  output logic                   pkt_start_o,
  output logic [63:0]            pkt_base_o,
  output logic [7:0]             spacing_o,
  output logic [N_THR*THR_W-1:0] thr_o,
  output logic                   err_clr_o,
  output logic                   phy_rst_o,
  output logic                   chan_rst_o
);
  wr_req_t           req;
  logic              rd_hit;
  logic [WORD_W-1:0] rd_word;
  logic [31:0]       cfg_rd, ctrl_rd;

  chan_addr_dec #(.N_CHAN(N_CHAN), .CHAN_ID(CHAN_ID)) i_dec (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_size_i, .wr_data_i, .rd_addr_i,
    .req_o(req), .rd_hit_o(rd_hit), .rd_word_o(rd_word)
  );

  chan_cfg_regs #(.N_THR(N_THR), .THR_W(THR_W)) i_cfg (
    .clk_i, .rst_ni, .req_i(req), .rd_word_i(rd_word), .rd_data_o(cfg_rd),
    .base_o(pkt_base_o), .spacing_o, .thr_o
  );

  chan_mode_ctl i_mode (
    .clk_i, .rst_ni, .req_i(req), .pkt_done_i, .reg_mode_o, .busy_err_o,
    .pkt_start_o, .err_clr_o, .phy_rst_o, .chan_rst_o, .ctrl_rd_o(ctrl_rd)
  );

  assign rd_data_o = !rd_hit ? 32'b0 : (rd_word == W_CTRL) ? ctrl_rd : cfg_rd;

  // R2
  foreign_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_addr_i[ADDR_W-1:WIN_LOG2] != SEL_W'(CHAN_ID)) |=> (!pkt_start_o && !err_clr_o && !chan_rst_o && !phy_rst_o));
endmodule

// File: tb/test_chan_ctrl_regs.sv
module test_chan_ctrl_regs;
  localparam int CLK_P = 10;

  logic        clk = 0, rst_ni = 0;
  logic        wr_en_i = 0, pkt_done_i = 0;
  logic [15:0] wr_addr_i = 0, rd_addr_i = 0;
  logic [1:0]  wr_size_i = 0;
  logic [31:0] wr_data_i = 0, rd_data_o;
  logic        reg_mode_o, busy_err_o, pkt_start_o, err_clr_o, phy_rst_o, chan_rst_o;
  logic [63:0] pkt_base_o, thr_o;
  logic [7:0]  spacing_o;

  chan_ctrl_regs i_chan_ctrl_regs (
    .clk_i(clk), .rst_ni, .wr_en_i, .wr_addr_i, .wr_size_i, .wr_data_i, .rd_addr_i,
    .rd_data_o, .pkt_done_i, .reg_mode_o, .busy_err_o, .pkt_start_o, .pkt_base_o,
    .spacing_o, .thr_o, .err_clr_o, .phy_rst_o, .chan_rst_o
  );

  always #(CLK_P/2) clk = ~clk;

  typedef struct { int sel; logic [63:0] exp; string tag; } item_t;
  item_t exp_q[$];
  int checks = 0, errors = 0;
  bit finished = 0;

  // monitor: pulse vector = {start, chan_rst, phy_rst, err_clr, reg_mode}
  initial forever begin
    @(negedge clk); #1;
    if (exp_q.size() > 0) begin
      item_t it;
      logic [63:0] act;
      it = exp_q.pop_front();
      case (it.sel)
        0: act = {32'b0, rd_data_o};
        1: act = {59'b0, pkt_start_o, chan_rst_o, phy_rst_o, err_clr_o, reg_mode_o};
        default: act = pkt_base_o;
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [15:0] a, input logic [1:0] sz, input logic [31:0] v);
    @(negedge clk);
    wr_en_i = 1; wr_addr_i = a; wr_size_i = sz; wr_data_i = v << (8 * a[1:0]);
    @(negedge clk);
    wr_en_i = 0;
  endtask

  task automatic exp_rd(input logic [15:0] a, input logic [31:0] e, input string tag);
    rd_addr_i = a;
    exp_q.push_back('{0, {32'b0, e}, tag});
    @(negedge clk);
  endtask

  task automatic exp_pl(input logic [4:0] e, input string tag);
    exp_q.push_back('{1, {59'b0, e}, tag});
    @(negedge clk);
  endtask

  task automatic exp_base(input logic [63:0] e, input string tag);
    exp_q.push_back('{2, e, tag});
    @(negedge clk);
  endtask

  task automatic done_pulse();
    @(negedge clk); pkt_done_i = 1;
    @(negedge clk); pkt_done_i = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R1 reset state
    exp_pl(5'b00001, "R1 pulses");
    exp_rd(16'h4900, 32'h2, "R1 ctrl");
    exp_rd(16'h4710, 32'h0, "R1 base lo");
    exp_rd(16'h4714, 32'h0, "R1 base hi");
    exp_rd(16'h4718, 32'd6, "R1 spacing");
    exp_rd(16'h4800, 32'd32, "R1 thr0");
    exp_rd(16'h4804, 32'd32, "R1 thr1");
    exp_rd(16'h4808, 32'd10, "R1 thr2");
    exp_rd(16'h480C, 32'd8, "R1 thr3");
    // R2 other channel window
    wr(16'h0710, 2'd2, 32'h1234);
    exp_rd(16'h4710, 32'h0, "R2 foreign write");
    exp_rd(16'h0710, 32'h0, "R2 foreign read");
    wr(16'h0A00, 2'd2, 32'h107);
    exp_pl(5'b00001, "R2 foreign run");
    // R4 base
    wr(16'h4710, 2'd2, 32'h89ABCDEF);
    wr(16'h4714, 2'd2, 32'h01234567);
    exp_rd(16'h4710, 32'h89ABCDEF, "R4 base lo");
    exp_rd(16'h4714, 32'h01234567, "R4 base hi");
    wr(16'h4712, 2'd0, 32'h5A);
    exp_rd(16'h4710, 32'h895ACDEF, "R4 byte lane");
    // R3 sizes and alignment
    wr(16'h4716, 2'd1, 32'hBEEF);
    exp_rd(16'h4714, 32'hBEEF4567, "R3 half upper");
    wr(16'h4711, 2'd1, 32'h1111);
    exp_rd(16'h4710, 32'h895ACDEF, "R3 odd half ignored");
    wr(16'h4712, 2'd2, 32'h2222);
    exp_rd(16'h4710, 32'h895ACDEF, "R3 misaligned word ignored");
    exp_rd(16'h4712, 32'h0, "R3 misaligned read");
    // R5 spacing and thresholds
    wr(16'h4718, 2'd2, 32'hFFFFFF07);
    exp_rd(16'h4718, 32'h07, "R5 spacing");
    wr(16'h4804, 2'd1, 32'h0040);
    exp_rd(16'h4804, 32'h40, "R5 thr1");
    wr(16'h480C, 2'd2, 32'hFFFF0011);
    exp_rd(16'h480C, 32'h11, "R5 thr3 upper zero");
    // R7 non-run writes to command
    wr(16'h4A00, 2'd2, 32'h108);
    exp_pl(5'b00001, "R7 wrong value");
    wr(16'h4A00, 2'd0, 32'h07);
    exp_pl(5'b00001, "R7 byte write");
    // R6 run
    wr(16'h4A00, 2'd2, 32'h107);
    exp_pl(5'b10000, "R6 start pulse");
    exp_base(64'hBEEF4567_895ACDEF, "R6 base out");
    exp_pl(5'b00000, "R6 pulse ends");
    exp_rd(16'h4900, 32'h0, "R6 packet mode");
    // R8 run while busy
    wr(16'h4A00, 2'd2, 32'h107);
    exp_pl(5'b00000, "R8 no start");
    exp_rd(16'h4900, 32'h80, "R8 busy err");
    // R9 done
    done_pulse();
    exp_rd(16'h4900, 32'h82, "R9 done returns");
    // R10 error clear
    wr(16'h4900, 2'd0, 32'h04);
    exp_pl(5'b00011, "R10 clr pulse");
    exp_rd(16'h4900, 32'h02, "R10 busy cleared");
    exp_pl(5'b00001, "R10 pulse ends");
    // R9 return by control write
    wr(16'h4A00, 2'd2, 32'h107);
    exp_rd(16'h4900, 32'h0, "R9 in packet");
    wr(16'h4900, 2'd0, 32'h02);
    exp_pl(5'b00001, "R9 ctrl write");
    exp_rd(16'h4900, 32'h02, "R9 ctrl readback");
    // R11 resets
    wr(16'h4A00, 2'd2, 32'h107);
    wr(16'h4A00, 2'd2, 32'h107);
    exp_rd(16'h4900, 32'h80, "R11 pre busy");
    wr(16'h4901, 2'd0, 32'h12);
    exp_pl(5'b01101, "R11 both resets");
    exp_rd(16'h4900, 32'h02, "R11 after reset");
    wr(16'h4901, 2'd0, 32'h02);
    exp_pl(5'b00101, "R11 phy only");
    exp_pl(5'b00001, "R11 pulses end");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule